// File: doc/BRIEF.md
# Indirect-Address Byte Register Bridge

This block lets an 8-bit host port, with only eight byte locations selected by a 3-bit address, reach a 4096-word, 32-bit internal register space. The host first loads a 12-bit internal address into two address registers. It then moves data through four byte-wide holding registers. Touching data byte 0 is what starts the real internal cycle. A write to byte 0 sends the whole 32-bit holding word to the addressed location. A read of byte 0 fetches the addressed word into the holding registers and returns its low byte. The host can then collect the other bytes in any order. An internal cycle occupies two clocks. During that time `busy` is high and the block ignores host strobes.

Two control bits in the upper address register make the internal address step forward by one after a read cycle, after a write cycle, or after both. This allows the host to stream through consecutive locations. Location 5 accepts a write-only synchronisation command. The command issues one-cycle start, hop and beam pulses to any mix of four channels. Location 4 is a plain byte register whose halves drive per-channel sleep and program levels. The internal target is a simple synchronous memory model that clears to zero on reset.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, both address registers, the holding word and the location-4 register are zero. `bus_rdata`, `rd_valid`, `busy` and all sync outputs are 0.
- R2: Location 7 stores a full byte. Bits [3:0] are internal address bits [11:8], bit 6 enables increment after reads and bit 7 enables increment after writes. Location 6 stores internal address bits [7:0]. Both read back their stored values.
- R3: Locations 3, 2, 1 and 0 map to holding bits [31:24], [23:16], [15:8] and [7:0]. A write to locations 1 to 3 only stores the byte and does not raise `busy`.
- R4: A write to location 0 stores bits [7:0] and then writes the full holding word to the internal address. `busy` stays high for exactly two cycles when no increment follows.
- R5: A read of location 0 loads the addressed word into the holding registers. Two cycles later, `rd_valid` pulses with bits [7:0] on `bus_rdata`. Later reads of locations 1 to 3 return the other bytes of that word.
- R6: Reading locations 1 to 3 before location 0 returns the bytes left from the previous transfer.
- R7: When the increment bit for the cycle type is set, the 12-bit address rises by one in a third busy cycle after the access, wrapping from 0xFFF to 0x000. Location 7 bits [7:4] are unchanged by the increment.
- R8: A write to location 5 pulses, for one cycle, `sync_start` when data bit 4 is set, `sync_hop` when bit 5 is set and `sync_beam` when bit 6 is set. Each pulse appears on the channels set in data bits [3:0], where bit 0 is channel index 0. Reading location 5 returns 0.
- R9: Location 4 reads back its stored byte. Bits [3:0] drive `chan_sleep` and bits [7:4] drive `chan_prog`.
- R10: Host strobes that arrive while `busy` is high have no effect.
- R11: Every internal location reads as zero after reset.
- R12: A read of any location other than 0 returns its byte on `bus_rdata`, with `rd_valid` high, in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | One-cycle host write strobe |
| bus_rd | input | 1 | One-cycle host read strobe |
| bus_addr | input | 3 | Host byte location |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Returned read byte |
| rd_valid | output | 1 | `bus_rdata` holds a new read result |
| busy | output | 1 | Internal cycle in progress, strobes ignored |
| sync_start | output | 4 | Per-channel start pulses |
| sync_hop | output | 4 | Per-channel hop pulses |
| sync_beam | output | 4 | Per-channel beam pulses |
| chan_sleep | output | 4 | Per-channel sleep level |
| chan_prog | output | 4 | Per-channel program level |

## Verification
The embedded properties watch four things on every cycle:
- no sync pulse appears without a matching host write;
- the address registers do not move during a busy cycle other than the increment cycle;
- the holding load only follows an internal read;
- an increment only follows an access whose type has its enable set.

Other behaviours depend on values travelling through memory and the byte lanes, and only the scenarios can show them. These are: the byte order of the holding word, stale bytes returned before a byte-0 read, the two- or three-cycle busy length, and the wrap from 0xFFF.

// File: rtl/ibr_pkg.sv
// Shared types and host location codes for the indirect-address bridge.
// Assumes a 3-bit host location space with a fixed layout.
package ibr_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ACC1,
        SQ_ACC2,
        SQ_INC
    } sq_state_t;

    localparam int          EXT_AW   = 3;
    localparam logic [2:0]  EA_BYTE0 = 3'd0;
    localparam logic [2:0]  EA_PWR   = 3'd4;
    localparam logic [2:0]  EA_SYNC  = 3'd5;
    localparam logic [2:0]  EA_LO    = 3'd6;
    localparam logic [2:0]  EA_HI    = 3'd7;
    localparam int          HI_WINC  = 7;
    localparam int          HI_RINC  = 6;
endpackage

// File: rtl/ibr_mem.sv
// Internal target model: synchronous word memory, cleared on reset.
// Assumes one request per cycle. A read result appears the cycle after req.
module ibr_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // Clear on reset, otherwise perform the requested write or read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
            rdata <= '0;
        end else if (req) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/ibr_seq.sv
// Access sequencer: two-cycle internal access, then an optional increment cycle.
// Assumes go strobes arrive only while idle (the top gates them with busy).
module ibr_seq
    import ibr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic rd_go,
    input  logic inc_wr_en,
    input  logic inc_rd_en,
    output logic busy,
    output logic mem_req,
    output logic mem_we,
    output logic ld_hold,
    output logic inc_pulse
);
    sq_state_t state;
    logic      is_wr;

    // Step through idle, issue, complete and optional increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            is_wr <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (wr_go) begin
                        state <= SQ_ACC1;
                        is_wr <= 1'b1;
                    end else if (rd_go) begin
                        state <= SQ_ACC1;
                        is_wr <= 1'b0;
                    end
                end
                SQ_ACC1: state <= SQ_ACC2;
                SQ_ACC2: state <= (is_wr ? inc_wr_en : inc_rd_en) ? SQ_INC : SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode strobes for memory, holding load and address increment.
    always_comb begin
        busy      = (state != SQ_IDLE);
        mem_req   = (state == SQ_ACC1);
        mem_we    = is_wr;
        ld_hold   = (state == SQ_ACC2) && !is_wr;
        inc_pulse = (state == SQ_INC);
    end

    // R4
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R5
    hold_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hold |-> $past(mem_req && !mem_we));
    // R7
    inc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse |-> ($past(mem_req, 2) && ($past(mem_we, 2) ? inc_wr_en : inc_rd_en)));
endmodule

// File: rtl/ibr_regfile.sv
// Host-visible byte registers: address pair, holding word, power byte, sync command.
// Assumes wr_en/rd_en are already gated by busy, and write wins over read.
module ibr_regfile
    import ibr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NCH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [EXT_AW-1:0] ext_addr,
    input  logic [7:0]        ext_wdata,
    input  logic              busy,
    input  logic              ld_hold,
    input  logic              inc_pulse,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] hold_q,
    output logic              inc_wr_en,
    output logic              inc_rd_en,
    output logic [7:0]        rdata,
    output logic              rd_valid,
    output logic [NCH-1:0]    sync_start,
    output logic [NCH-1:0]    sync_hop,
    output logic [NCH-1:0]    sync_beam,
    output logic [NCH-1:0]    chan_sleep,
    output logic [NCH-1:0]    chan_prog
);
    localparam int NBYTE = DATA_W / 8;
    localparam int HI_W  = ADDR_W - 8;
    localparam int B_ST  = NCH;
    localparam int B_HOP = NCH + 1;
    localparam int B_BM  = NCH + 2;

    logic [7:HI_W] ctl_q;
    logic [7:0]    pwr_q;
    logic [7:0]    rb;
    logic          sync_wr;

    assign inc_wr_en  = ctl_q[HI_WINC];
    assign inc_rd_en  = ctl_q[HI_RINC];
    assign chan_sleep = pwr_q[NCH-1:0];
    assign chan_prog  = pwr_q[2*NCH-1:NCH];
    assign sync_wr    = wr_en && (ext_addr == EA_SYNC);

    // Address pair: host writes, or a post-access increment with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            ctl_q  <= '0;
        end else if (inc_pulse) begin
            addr_q <= addr_q + 1'b1;
        end else if (wr_en && ext_addr == EA_HI) begin
            ctl_q              <= ext_wdata[7:HI_W];
            addr_q[ADDR_W-1:8] <= ext_wdata[HI_W-1:0];
        end else if (wr_en && ext_addr == EA_LO) begin
            addr_q[7:0] <= ext_wdata;
        end
    end

    // Holding word: byte writes from the host, whole-word load after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (ld_hold) begin
            hold_q <= mem_q;
        end else if (wr_en) begin
            for (int i = 0; i < NBYTE; i++)
                if (ext_addr == EXT_AW'(i)) hold_q[8*i +: 8] <= ext_wdata;
        end
    end

    // Power byte at location 4.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pwr_q <= '0;
        else if (wr_en && ext_addr == EA_PWR) pwr_q <= ext_wdata;
    end

    // One-cycle sync pulses per channel and type.
    for (genvar c = 0; c < NCH; c++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync_start[c] <= 1'b0;
                sync_hop[c]   <= 1'b0;
                sync_beam[c]  <= 1'b0;
            end else begin
                sync_start[c] <= sync_wr && ext_wdata[c] && ext_wdata[B_ST];
                sync_hop[c]   <= sync_wr && ext_wdata[c] && ext_wdata[B_HOP];
                sync_beam[c]  <= sync_wr && ext_wdata[c] && ext_wdata[B_BM];
            end
        end
    end

    // Readback selection for the host location.
    always_comb begin
        case (ext_addr)
            EA_HI:   rb = {ctl_q, addr_q[ADDR_W-1:8]};
            EA_LO:   rb = addr_q[7:0];
            EA_PWR:  rb = pwr_q;
            EA_SYNC: rb = 8'h00;
            default: rb = hold_q[8*ext_addr[1:0] +: 8];
        endcase
    end

    // Read result: direct locations next cycle, byte 0 after the internal read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else if (ld_hold) begin
            rdata    <= mem_q[7:0];
            rd_valid <= 1'b1;
        end else if (rd_en && ext_addr != EA_BYTE0) begin
            rdata    <= rb;
            rd_valid <= 1'b1;
        end else begin
            rd_valid <= 1'b0;
        end
    end

    // R8
    sync_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{sync_start, sync_hop, sync_beam}) |-> $past(sync_wr));
    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inc_pulse) |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/ibr_bridge.sv
// Top: byte-wide host port reaching a word memory through indirect addressing.
// Assumes single-cycle strobes. Strobes during busy are dropped.
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int NCH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [EXT_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              rd_valid,
    output logic              busy,
    output logic [NCH-1:0]    sync_start,
    output logic [NCH-1:0]    sync_hop,
    output logic [NCH-1:0]    sync_beam,
    output logic [NCH-1:0]    chan_sleep,
    output logic [NCH-1:0]    chan_prog
);
    logic              wr_en, rd_en, wr_go, rd_go;
    logic              inc_wr_en, inc_rd_en;
    logic              mem_req, mem_we, ld_hold, inc_pulse;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] hold_q, mem_q;

    // Gate host strobes with busy and find the byte-0 triggers.
    always_comb begin
        wr_en = bus_wr && !busy;
        rd_en = bus_rd && !busy && !bus_wr;
        wr_go = wr_en && (bus_addr == EA_BYTE0);
        rd_go = rd_en && (bus_addr == EA_BYTE0);
    end

    ibr_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .ext_addr(bus_addr), .ext_wdata(bus_wdata), .busy(busy),
        .ld_hold(ld_hold), .inc_pulse(inc_pulse), .mem_q(mem_q),
        .addr_q(addr_q), .hold_q(hold_q), .inc_wr_en(inc_wr_en),
        .inc_rd_en(inc_rd_en), .rdata(bus_rdata), .rd_valid(rd_valid),
        .sync_start(sync_start), .sync_hop(sync_hop), .sync_beam(sync_beam),
        .chan_sleep(chan_sleep), .chan_prog(chan_prog)
    );

    ibr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .rd_go(rd_go),
        .inc_wr_en(inc_wr_en), .inc_rd_en(inc_rd_en), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .ld_hold(ld_hold),
        .inc_pulse(inc_pulse)
    );

    ibr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .req(mem_req), .we(mem_we),
        .addr(addr_q), .wdata(hold_q), .rdata(mem_q)
    );
endmodule

// File: tb/ibr_bridge_tb.sv
// Bench: a vector table walked in one loop, then directed reset and corner tests.
module ibr_bridge_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rd_valid, busy;
    logic [3:0] sync_start, sync_hop, sync_beam, chan_sleep, chan_prog;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    ibr_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_valid(rd_valid), .busy(busy), .sync_start(sync_start),
        .sync_hop(sync_hop), .sync_beam(sync_beam), .chan_sleep(chan_sleep),
        .chan_prog(chan_prog)
    );

    localparam logic [3:0] OW = 4'd1, OR = 4'd2;
    // Fields: {req, op, location, write byte, expected read byte}
    localparam int NV = 51;
    localparam logic [27:0] VEC [NV] = '{
        {4'd2, OW, 4'd7, 8'h00, 8'h00},   // R2 upper address
        {4'd2, OW, 4'd6, 8'h10, 8'h00},   // R2 lower address
        {4'd3, OW, 4'd3, 8'hDE, 8'h00},   // R3 byte lanes
        {4'd3, OW, 4'd2, 8'hAD, 8'h00},
        {4'd3, OW, 4'd1, 8'hBE, 8'h00},
        {4'd4, OW, 4'd0, 8'hEF, 8'h00},   // R4 launch write
        {4'd5, OR, 4'd0, 8'h00, 8'hEF},   // R5 byte-0 read
        {4'd5, OR, 4'd3, 8'h00, 8'hDE},
        {4'd5, OR, 4'd1, 8'h00, 8'hBE},
        {4'd5, OR, 4'd2, 8'h00, 8'hAD},
        {4'd2, OR, 4'd7, 8'h00, 8'h00},
        {4'd2, OR, 4'd6, 8'h00, 8'h10},
        {4'd4, OW, 4'd6, 8'h20, 8'h00},   // R4 16-bit store
        {4'd4, OW, 4'd1, 8'h12, 8'h00},
        {4'd4, OW, 4'd0, 8'h34, 8'h00},
        {4'd4, OR, 4'd0, 8'h00, 8'h34},
        {4'd4, OR, 4'd1, 8'h00, 8'h12},
        {4'd4, OR, 4'd3, 8'h00, 8'hDE},
        {4'd7, OW, 4'd7, 8'hC0, 8'h00},   // R7 both increments
        {4'd7, OW, 4'd6, 8'h30, 8'h00},
        {4'd7, OW, 4'd3, 8'h11, 8'h00},
        {4'd7, OW, 4'd2, 8'h22, 8'h00},
        {4'd7, OW, 4'd1, 8'h33, 8'h00},
        {4'd7, OW, 4'd0, 8'h44, 8'h00},
        {4'd7, OR, 4'd6, 8'h00, 8'h31},
        {4'd7, OW, 4'd0, 8'h55, 8'h00},
        {4'd7, OR, 4'd6, 8'h00, 8'h32},
        {4'd7, OW, 4'd6, 8'h30, 8'h00},
        {4'd7, OR, 4'd0, 8'h00, 8'h44},
        {4'd7, OR, 4'd0, 8'h00, 8'h55},
        {4'd7, OR, 4'd6, 8'h00, 8'h32},
        {4'd6, OW, 4'd6, 8'h10, 8'h00},   // R6 stale bytes
        {4'd6, OR, 4'd3, 8'h00, 8'h11},
        {4'd6, OR, 4'd0, 8'h00, 8'hEF},
        {4'd6, OR, 4'd3, 8'h00, 8'hDE},
        {4'd7, OW, 4'd7, 8'h40, 8'h00},   // R7 read-only increment
        {4'd7, OW, 4'd6, 8'h40, 8'h00},
        {4'd7, OW, 4'd0, 8'h66, 8'h00},
        {4'd7, OR, 4'd6, 8'h00, 8'h40},
        {4'd7, OR, 4'd0, 8'h00, 8'h66},
        {4'd7, OR, 4'd6, 8'h00, 8'h41},
        {4'd7, OW, 4'd7, 8'h80, 8'h00},   // R7 write-only increment
        {4'd7, OW, 4'd6, 8'h50, 8'h00},
        {4'd11, OR, 4'd0, 8'h00, 8'h00},  // R11 cleared memory
        {4'd7, OR, 4'd6, 8'h00, 8'h50},
        {4'd11, OR, 4'd3, 8'h00, 8'h00},
        {4'd7, OW, 4'd0, 8'h77, 8'h00},
        {4'd7, OR, 4'd6, 8'h00, 8'h51},
        {4'd9, OW, 4'd4, 8'hA5, 8'h00},   // R9 power byte
        {4'd9, OR, 4'd4, 8'h00, 8'hA5},
        {4'd8, OR, 4'd5, 8'h00, 8'h00}    // R8 sync reads zero
    };

    task automatic chk(input int req, input logic [7:0] got, input logic [7:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%02h expected=%02h", req, what, got, exp);
        end
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20) begin @(negedge clk); n++; end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        wait_idle();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_idle();
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
        int n = 0;
        wait_idle();
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        while (!rd_valid && n < 20) begin @(negedge clk); n++; end
        d = rd_valid ? bus_rdata : 8'hXX;
        wait_idle();
    endtask

    task automatic busy_len(input logic [7:0] d, output int len);
        wait_idle();
        bus_addr = 3'd0; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        len = 0;
        while (busy && len < 20) begin len++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        int         len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(1, {7'd0, busy}, 8'h00, "busy after reset");
        chk(1, {7'd0, rd_valid}, 8'h00, "rd_valid after reset");
        chk(1, bus_rdata, 8'h00, "rdata after reset");
        chk(1, {sync_start, sync_hop}, 8'h00, "sync after reset");
        chk(1, {chan_prog, chan_sleep}, 8'h00, "power outputs after reset");
        host_rd(3'd7, rv); chk(1, rv, 8'h00, "upper address after reset");
        host_rd(3'd4, rv); chk(1, rv, 8'h00, "power byte after reset");
        host_rd(3'd2, rv); chk(1, rv, 8'h00, "holding after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][23:20] == OW) begin
                host_wr(VEC[i][18:16], VEC[i][15:8]);
            end else begin
                host_rd(VEC[i][18:16], rv);
                chk(int'(VEC[i][27:24]), rv, VEC[i][7:0], $sformatf("vector %0d", i));
            end
        end
        // R9 power outputs follow location 4 (A5 written above)
        chk(9, {4'd0, chan_sleep}, 8'h05, "chan_sleep");
        chk(9, {4'd0, chan_prog}, 8'h0A, "chan_prog");

        // R8 sync pulse: start on channel 1 only, for one cycle
        wait_idle();
        bus_addr = 3'd5; bus_wdata = 8'h12; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(8, {4'd0, sync_start}, 8'h02, "start pulse");
        chk(8, {sync_hop, sync_beam}, 8'h00, "hop/beam quiet");
        @(negedge clk);
        chk(8, {4'd0, sync_start}, 8'h00, "start pulse ends");
        // R8 hop and beam on every channel
        host_wr(3'd5, 8'h00);
        bus_addr = 3'd5; bus_wdata = 8'h6F; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(8, {sync_hop, sync_beam}, 8'hFF, "hop+beam all channels");
        chk(8, {4'd0, sync_start}, 8'h00, "no start");

        // R3 byte writes above 0 do not raise busy
        bus_addr = 3'd2; bus_wdata = 8'h9C; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(3, {7'd0, busy}, 8'h00, "byte 2 write idle");

        // R4 two busy cycles without increment, R7 three with
        host_wr(3'd7, 8'h00); host_wr(3'd6, 8'h60);
        busy_len(8'h01, len);
        chk(4, 8'(len), 8'd2, "busy length no increment");
        host_wr(3'd7, 8'h80);
        busy_len(8'h02, len);
        chk(7, 8'(len), 8'd3, "busy length with increment");

        // R10 a write during busy is dropped
        host_wr(3'd7, 8'h00); host_wr(3'd6, 8'h60);
        bus_addr = 3'd0; bus_wdata = 8'h03; bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 3'd6; bus_wdata = 8'h99;
        @(negedge clk);
        bus_wr = 1'b0;
        wait_idle();
        host_rd(3'd6, rv); chk(10, rv, 8'h60, "lower address kept during busy");

        // R7 wrap from 0xFFF, control bits kept
        host_wr(3'd7, 8'hCF); host_wr(3'd6, 8'hFF);
        host_wr(3'd0, 8'h04);
        host_rd(3'd7, rv); chk(7, rv, 8'hC0, "upper after wrap");
        host_rd(3'd6, rv); chk(7, rv, 8'h00, "lower after wrap");
        // R12 direct read is valid the cycle after the strobe
        bus_addr = 3'd7; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(12, {7'd0, rd_valid}, 8'h01, "rd_valid next cycle");
        chk(12, bus_rdata, 8'hC0, "direct read data");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule